// File: doc/BRIEF.md
# Dual-Strobe Mode-Selected Shift Register

This block is a short register chain of `WIDTH` stages (four by default) that is moved by two separate transfer strobes. A level on the mode input selects which strobe is live. In serial mode, a falling edge on the shift strobe moves every stage one place toward the last stage and takes the serial input into the first stage. In parallel mode, a falling edge on the load strobe copies the parallel input into all stages at once. The strobe that is not selected is ignored, and so is its data.

Shifting in the other direction needs no extra logic. The user wires each parallel input to the output of the next stage and feeds serial data into the parallel input of the last stage. Each load then moves the contents one place toward stage 0.

Both strobes and the mode level are treated as asynchronous levels. They pass through one synchroniser chain, so the mode value and the strobe value sampled at the same edge move through it together. Falling edges are detected in the system clock domain. The strobes, mode and data inputs are plain control pins: there is no valid/ready handshake and no back-pressure. A strobe edge is never refused or held; it is acted on or ignored according to mode. The register state is a plain output that is always valid.

Top module: `dual_strobe_shreg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all stages to zero and clears the synchronisers, so that no transfer follows reset release.
- R2: With mode low (`sel_load`=0), a falling edge of `shr_stb` sets stage 0 to `ser_in` and stage i to the old stage i-1. The old last stage is dropped. Stage i is bit i of `state`.
- R3: With mode low, `ld_stb` and `par_in` have no effect on `state`.
- R4: With mode high (`sel_load`=1), a falling edge of `ld_stb` sets stage i to `par_in[i]` for every i.
- R5: With mode high, `shr_stb` and `ser_in` have no effect on `state`.
- R6: `state` changes only on a high-to-low transition of the selected strobe. A rising edge, or a strobe held high or low, leaves it unchanged.
- R7: Take edge E0 as the rising clock edge that first samples a strobe low after it was high. `state` is still unchanged after edge SYNC_STAGES-1 and takes the new value at edge SYNC_STAGES, counted from E0. `ser_in` and `par_in` are used at that edge and must be held stable until it.
- R8: The two strobes may be driven from one source. The mode level then picks shift (low) or load (high), and exactly one operation happens per falling edge.
- R9: The mode level is sampled at the same clock edge as the strobe. When mode changes in the same sampled cycle in which the strobe goes low, the new mode value decides the operation.
- R10: With `par_in[i]` wired to stage i+1 and `par_in[WIDTH-1]` wired to serial data, each load moves the contents one stage toward stage 0 and puts the serial bit into the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_load | input | 1 | Mode level: 0 selects serial shift, 1 selects parallel load |
| shr_stb | input | 1 | Shift strobe; acts on its falling edge in serial mode |
| ld_stb | input | 1 | Load strobe; acts on its falling edge in parallel mode |
| ser_in | input | 1 | Serial data for stage 0 |
| par_in | input | WIDTH | Parallel data, bit i for stage i |
| state | output | WIDTH | Current register contents, bit i is stage i |

## Verification
The bench builds the block with its defaults, `WIDTH`=4 and `SYNC_STAGES`=2. At this width a few random shifts push a known bit through every stage and out past the last one, and the feedback load used for reverse shifting can be checked stage by stage. With two synchroniser stages, the bench can observe the exact edge at which the update lands (R7). It can also place a mode change in the same sample as a strobe fall (R9) and check the result. Random steps mix both modes, single and tied strobes, and rise-only pulses against a bench model.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } dss_op_e;
endpackage

// File: rtl/dss_sync_chain.sv
module dss_sync_chain #(
  parameter int NBITS  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] d_async,
  output logic [NBITS-1:0] d_sync
);
  logic [NBITS-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/dss_fall_detect.sv
module dss_fall_detect #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] lvl,
  output logic [NBITS-1:0] fall
);
  logic [NBITS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar b = 0; b < NBITS; b++) begin : g_edge
    assign fall[b] = prev_q[b] & ~lvl[b];

    // R6
    fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      fall[b] |=> !fall[b]);
  end
endmodule

// File: rtl/dss_core.sv
module dss_core
  import dss_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  dss_op_e          op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_SHIFT: nxt = {q[WIDTH-2:0], ser_in};
      OP_LOAD:  nxt = par_in;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q == $past(par_in)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(q));
endmodule

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg
  import dss_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_load,
  input  logic             shr_stb,
  input  logic             ld_stb,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] state
);
  localparam int NCTL = 3;

  logic [NCTL-1:0] ctl_sync;
  logic [1:0]      stb_fall;
  logic            sel_s, shr_fall, ld_fall;
  dss_op_e         op;

  // mode travels beside the strobes so both are sampled at the same edge (R9)
  dss_sync_chain #(.NBITS(NCTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({sel_load, ld_stb, shr_stb}),
    .d_sync  (ctl_sync)
  );

  dss_fall_detect #(.NBITS(2)) u_fall (
    .clk  (clk),
    .rst  (rst),
    .lvl  (ctl_sync[1:0]),
    .fall (stb_fall)
  );

  assign sel_s    = ctl_sync[2];
  assign shr_fall = stb_fall[0];
  assign ld_fall  = stb_fall[1];

  always_comb begin
    op = OP_HOLD;
    if (sel_s) begin
      if (ld_fall) op = OP_LOAD;
    end else begin
      if (shr_fall) op = OP_SHIFT;
    end
  end

  dss_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .ser_in (ser_in),
    .par_in (par_in),
    .q      (state)
  );

  // R3
  load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && ld_fall && !shr_fall) |=> $stable(state));

  // R5
  shift_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_s && shr_fall && !ld_fall) |=> $stable(state));

  // R6
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shr_fall && !ld_fall) |=> $stable(state));
endmodule

// File: tb/test_dual_strobe_shreg.sv
module test_dual_strobe_shreg;
  localparam int W     = 4;
  localparam int SYNC  = 2;
  localparam int TCLK  = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_load = 1'b0, shr_stb = 1'b0, ld_stb = 1'b0, ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] state;
  logic [W-1:0] model = '0;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #(TCLK/2) clk = ~clk;

  dual_strobe_shreg #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_dual_strobe_shreg (
    .clk(clk), .rst(rst), .sel_load(sel_load), .shr_stb(shr_stb),
    .ld_stb(ld_stb), .ser_in(ser_in), .par_in(par_in), .state(state)
  );

  function automatic logic [W-1:0] shift_fn(logic [W-1:0] q, logic s);
    return {q[W-2:0], s};
  endfunction

  function automatic logic [W-1:0] expect_fn(logic [W-1:0] q, logic m,
      bit us, bit ul, logic s, logic [W-1:0] p);
    if (!m && us) return shift_fn(q, s);
    if (m && ul)  return p;
    return q;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: state=%b expected=%b", tag, act, exp);
    end
  endtask

  // one strobe pulse: pre_m while high, m from the sample that sees it low
  task automatic do_op(input logic pre_m, input logic m, input bit us,
      input bit ul, input logic s, input logic [W-1:0] p, input string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    sel_load = pre_m; ser_in = s; par_in = p;
    shr_stb = us; ld_stb = ul;
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);
    check(state, model, {tag, " R6 rise"});
    shr_stb = 1'b0; ld_stb = 1'b0; sel_load = m;
    @(posedge clk);                   // E0
    repeat (SYNC - 1) @(posedge clk);
    @(negedge clk);
    check(state, model, {tag, " R7 early"});
    @(posedge clk);
    @(negedge clk);
    exp = expect_fn(model, m, us, ul, s, p);
    check(state, exp, tag);
    model = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: state=%b expected=done", state);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1975));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(state, '0, "R1 reset");
    rst = 1'b0;

    // directed serial shifts, bit leaves last stage
    do_op(1'b0, 1'b0, 1, 0, 1'b1, 4'h0, "R2 shift1");
    do_op(1'b0, 1'b0, 1, 0, 1'b0, 4'h0, "R2 shift0");
    do_op(1'b0, 1'b0, 1, 0, 1'b1, 4'h0, "R2 shift1b");
    do_op(1'b0, 1'b0, 1, 0, 1'b1, 4'h0, "R2 shift1c");
    do_op(1'b0, 1'b0, 1, 0, 1'b0, 4'h0, "R2 drop last");
    do_op(1'b0, 1'b0, 0, 1, 1'b1, 4'hF, "R3 load ignored");
    do_op(1'b1, 1'b1, 0, 1, 1'b0, 4'hA, "R4 load");
    do_op(1'b1, 1'b1, 1, 0, 1'b1, 4'h5, "R5 shift ignored");
    do_op(1'b0, 1'b0, 0, 0, 1'b1, 4'h3, "R6 no strobe");
    do_op(1'b1, 1'b1, 1, 1, 1'b0, 4'h6, "R8 tied load");
    do_op(1'b0, 1'b0, 1, 1, 1'b1, 4'h9, "R8 tied shift");
    do_op(1'b0, 1'b1, 1, 1, 1'b0, 4'hC, "R9 mode to load");
    do_op(1'b1, 1'b0, 1, 1, 1'b1, 4'h3, "R9 mode to shift");

    // R10: feedback wiring gives reverse shift
    for (int k = 0; k < 6; k++) begin
      logic sbit;
      logic [W-1:0] fb;
      sbit = 1'($urandom);
      fb = {sbit, model[W-1:1]};
      do_op(1'b1, 1'b1, 0, 1, 1'b0, fb, "R10 reverse");
    end

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic pm, mm;
      bit us, ul;
      pm = 1'($urandom);
      mm = ($urandom % 4 == 0) ? ~pm : pm;
      us = 1'($urandom);
      ul = ($urandom % 3 == 0) ? us : 1'($urandom);
      do_op(pm, mm, us, ul, 1'($urandom), W'($urandom), "R2/R4 random");
    end

    // reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(state, '0, "R1 mid reset");
    rst = 1'b0; model = '0;
    do_op(1'b0, 1'b0, 1, 0, 1'b1, 4'h0, "R2 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule